// File: doc/BRIEF.md
# Decode-Stage Next Fetch Address Selector

This block picks the address of the next instruction to fetch in a five-stage, 32-bit load/store pipeline. It holds the fetch PC as a word counter (PC_W bits; the two byte-offset bits are always zero and are not stored). The counter steps by one word on every sequential fetch.

Branches and jumps are resolved while they sit in decode. The block reads the decode instruction word, the word address that follows that instruction (carried down the pipe with it), and the value of the first source register. A dedicated adder forms the target from those inputs. When control flow changes, the new address is loaded into the fetch PC at the edge that ends decode. The redirect flag tells the pipeline to squash the one instruction already fetched behind the branch, so each taken branch or jump costs a single bubble.

Linking jumps raise a request to write the return address into register 31. The surrounding pipeline carries that request to write-back.

Top module: `npc_select`

## Requirements
- R1: While rst_ni is low, fetch_pc_o is 0 and redirect_o and link_we_o are 0. After rst_ni rises, the first fetch address is 0.
- R2: When redirect_o is 0, next_pc_o equals fetch_pc_o + 1 (one word), and fetch_pc_o takes that value at the next clock edge.
- R3: Opcode field [31:26] = 6'h04 (branch if zero) redirects only when rs1_val_i is zero. Its target word is (byte address {id_pc_next_i,2'b00} + immediate [15:0] sign-extended from bit 15) with the low two bits dropped.
- R4: Opcode 6'h05 (branch if nonzero) redirects only when rs1_val_i is nonzero. It uses the same target as R3.
- R5: Opcode 6'h02 (relative jump) always redirects. Its target is {id_pc_next_i,2'b00} + offset [25:0] sign-extended from bit 25, with the low two bits dropped.
- R6: Opcode 6'h03 (relative jump and link) redirects to the R5 target and raises a link request.
- R7: Opcode 6'h12 (register jump) always redirects to rs1_val_i[31:2]. A misaligned register value is truncated to its word.
- R8: Opcode 6'h13 (register jump and link) redirects to the R7 target and raises a link request.
- R9: A link request sets link_we_o = 1, link_addr_o = 31 and link_data_o = {id_pc_next_i,2'b00}. Any other cycle has link_we_o = 0.
- R10: When redirect_o is 1, next_pc_o is the target, and fetch_pc_o equals that target after the next clock edge.
- R11: When id_valid_i is 0, or the opcode is none of those above, there is no redirect and no link request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_valid_i | input | 1 | Decode slot holds a live instruction |
| id_instr_i | input | 32 | Instruction word in decode |
| id_pc_next_i | input | PC_W | Word address following the decode instruction |
| rs1_val_i | input | 32 | Value of register selected by [25:21] |
| fetch_pc_o | output | PC_W | Current fetch word address |
| next_pc_o | output | PC_W | Word address to fetch next |
| redirect_o | output | 1 | Control transfer taken; squash the fetch in flight |
| link_we_o | output | 1 | Return-address write request |
| link_addr_o | output | 5 | Destination register of the link write |
| link_data_o | output | 32 | Return byte address |

## Verification
The hardest cases to reach from the ports are the sign-extension boundaries. These are a branch immediate or jump offset with its top bit set, which must subtract from the carried PC, and a register target with nonzero low bits. Directed steps use offsets of all ones and of a single top bit, and register values ending in 01, 10 and 11. A mid-run reset is asserted while a jump sits in decode, to show that the redirect stays silent during reset. Random streams then mix every opcode with zero and nonzero register values.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned OFS_W   = 26;
  localparam int unsigned LINK_REG = 31;

  localparam logic [OP_W-1:0] OP_BRZ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BRNZ  = 6'h05;
  localparam logic [OP_W-1:0] OP_JREL  = 6'h02;
  localparam logic [OP_W-1:0] OP_JRELL = 6'h03;
  localparam logic [OP_W-1:0] OP_JREG  = 6'h12;
  localparam logic [OP_W-1:0] OP_JREGL = 6'h13;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_BRZ  = 3'd1,
    K_BRNZ = 3'd2,
    K_JREL = 3'd3,
    K_JREG = 3'd4
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  link;
  } ctl_t;
endpackage

// File: rtl/npc_classify.sv
module npc_classify
  import npc_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o.kind = K_NONE;
    ctl_o.link = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_BRZ:   ctl_o.kind = K_BRZ;
        OP_BRNZ:  ctl_o.kind = K_BRNZ;
        OP_JREL:  ctl_o.kind = K_JREL;
        OP_JRELL: begin ctl_o.kind = K_JREL; ctl_o.link = 1'b1; end
        OP_JREG:  ctl_o.kind = K_JREG;
        OP_JREGL: begin ctl_o.kind = K_JREG; ctl_o.link = 1'b1; end
        default:  ctl_o.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  kind_e           kind_i,
  input  logic [XLEN-1:0] rs1_i,
  output logic            taken_o
);
  logic is_zero;
  assign is_zero = (rs1_i == '0);

  always_comb begin
    unique case (kind_i)
      K_BRZ:   taken_o = is_zero;
      K_BRNZ:  taken_o = !is_zero;
      K_JREL,
      K_JREG:  taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned PC_W = 30,
  localparam int unsigned XLEN = PC_W + 2
) (
  input  kind_e                kind_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [PC_W-1:0]      pc_next_i,
  input  logic [XLEN-1:0]      rs1_i,
  output logic [PC_W-1:0]      target_o
);
  logic [XLEN-1:0] base_b, imm_b, ofs_b, disp_b, sum_b;

  assign base_b = {pc_next_i, 2'b00};
  assign imm_b  = {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
  assign ofs_b  = {{(XLEN-OFS_W){instr_i[OFS_W-1]}}, instr_i[OFS_W-1:0]};
  // one shared adder; displacement mux in front of it
  assign disp_b = (kind_i == K_JREL) ? ofs_b : imm_b;
  assign sum_b  = base_b + disp_b;

  always_comb begin
    if (kind_i == K_JREG) target_o = rs1_i[XLEN-1:2];
    else                  target_o = sum_b[XLEN-1:2];
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned PC_W = 30,
  localparam int unsigned XLEN = PC_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               id_valid_i,
  input  logic [INSTR_W-1:0] id_instr_i,
  input  logic [PC_W-1:0]    id_pc_next_i,
  input  logic [XLEN-1:0]    rs1_val_i,
  output logic [PC_W-1:0]    fetch_pc_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               redirect_o,
  output logic               link_we_o,
  output logic [4:0]         link_addr_o,
  output logic [XLEN-1:0]    link_data_o
);
  ctl_t            ctl;
  logic            taken;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] pc_q;

  npc_classify u_cls (
    .valid_i (id_valid_i),
    .op_i    (id_instr_i[INSTR_W-1 -: OP_W]),
    .ctl_o   (ctl)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (ctl.kind),
    .rs1_i   (rs1_val_i),
    .taken_o (taken)
  );

  npc_target #(.PC_W(PC_W)) u_tgt (
    .kind_i    (ctl.kind),
    .instr_i   (id_instr_i),
    .pc_next_i (id_pc_next_i),
    .rs1_i     (rs1_val_i),
    .target_o  (target)
  );

  assign redirect_o = rst_ni & taken;
  assign next_pc_o  = redirect_o ? target : pc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= next_pc_o;
  end

  assign fetch_pc_o  = pc_q;
  assign link_we_o   = rst_ni & ctl.link;
  assign link_addr_o = 5'(LINK_REG);
  assign link_data_o = {id_pc_next_i, 2'b00};
endmodule

// File: rtl/npc_select_chk.sv
module npc_select_chk
  import npc_pkg::*;
#(
  parameter int unsigned PC_W = 30,
  localparam int unsigned XLEN = PC_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               id_valid_i,
  input logic [INSTR_W-1:0] id_instr_i,
  input logic [XLEN-1:0]    rs1_val_i,
  input logic [PC_W-1:0]    fetch_pc_o,
  input logic [PC_W-1:0]    next_pc_o,
  input logic               redirect_o,
  input logic               link_we_o
);
  logic [OP_W-1:0] op;
  assign op = id_instr_i[INSTR_W-1 -: OP_W];

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!redirect_o && !link_we_o && fetch_pc_o == '0));

  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |=> fetch_pc_o == $past(fetch_pc_o) + 1'b1);

  assert_brz_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && op == OP_BRZ && rs1_val_i != '0) |-> !redirect_o);

  assert_brnz_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && op == OP_BRNZ && rs1_val_i == '0) |-> !redirect_o);

  assert_jump_always_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && (op == OP_JREL || op == OP_JREG)) |-> redirect_o);

  assert_link_with_jump_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> redirect_o);

  assert_redirect_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> fetch_pc_o == $past(next_pc_o));

  assert_idle_slot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!redirect_o && !link_we_o));
endmodule

bind npc_select npc_select_chk #(.PC_W(PC_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_valid_i (id_valid_i),
  .id_instr_i (id_instr_i),
  .rs1_val_i  (rs1_val_i),
  .fetch_pc_o (fetch_pc_o),
  .next_pc_o  (next_pc_o),
  .redirect_o (redirect_o),
  .link_we_o  (link_we_o)
);

// File: tb/npc_select_tb_top.sv
module npc_select_tb_top;
  localparam int PC_W = 30;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        id_valid_i;
  logic [31:0] id_instr_i;
  logic [29:0] id_pc_next_i;
  logic [31:0] rs1_val_i;
  logic [29:0] fetch_pc_o, next_pc_o;
  logic        redirect_o, link_we_o;
  logic [4:0]  link_addr_o;
  logic [31:0] link_data_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [29:0] model_pc;

  always #10 clk_i = ~clk_i;

  npc_select #(.PC_W(PC_W)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected behaviour from the requirements
  task automatic step(input bit rst, input bit v, input logic [31:0] ins,
                      input logic [29:0] pcn, input logic [31:0] rs, input string tag);
    bit          e_red, e_link;
    logic [31:0] e_tgt_b;
    logic [29:0] e_next;
    logic [5:0]  op;
    @(negedge clk_i);
    rst_ni = rst; id_valid_i = v; id_instr_i = ins; id_pc_next_i = pcn; rs1_val_i = rs;
    if (!rst) model_pc = '0;
    #3;
    op = ins[31:26];
    e_red = 0; e_link = 0; e_tgt_b = '0;
    if (v) begin
      case (op)
        6'h04: begin e_red = (rs == 0); e_tgt_b = {pcn,2'b00} + {{16{ins[15]}}, ins[15:0]}; end
        6'h05: begin e_red = (rs != 0); e_tgt_b = {pcn,2'b00} + {{16{ins[15]}}, ins[15:0]}; end
        6'h02, 6'h03: begin e_red = 1; e_link = (op == 6'h03);
                        e_tgt_b = {pcn,2'b00} + {{6{ins[25]}}, ins[25:0]}; end
        6'h12, 6'h13: begin e_red = 1; e_link = (op == 6'h13); e_tgt_b = rs; end
        default: ;
      endcase
    end
    if (!rst) begin
      e_red = 0; e_link = 0;
    end
    e_next = e_red ? e_tgt_b[31:2] : model_pc + 30'd1;
    check(fetch_pc_o === model_pc, rst ? "R2" : "R1", "fetch_pc", fetch_pc_o, model_pc);
    check(redirect_o === e_red, rst ? tag : "R1", "redirect", redirect_o, e_red);
    check(link_we_o === e_link, rst ? "R9" : "R1", "link_we", link_we_o, e_link);
    if (rst) begin
      check(next_pc_o === e_next, e_red ? "R10" : "R2", "next_pc", next_pc_o, e_next);
      if (e_link) begin
        check(link_addr_o === 5'd31, "R9", "link_addr", link_addr_o, 31);
        check(link_data_o === {pcn,2'b00}, "R9", "link_data", link_data_o, {pcn,2'b00});
      end
      model_pc = e_next;
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] low);
    return {op, low};
  endfunction

  initial begin
    rst_ni = 0; id_valid_i = 0; id_instr_i = '0; id_pc_next_i = '0; rs1_val_i = '0;
    model_pc = '0;
    // R1 reset with a jump presented
    step(0, 1, mk(6'h02, 26'h10), 30'h40, 0, "R1");
    step(0, 1, mk(6'h13, 26'h0),  30'h40, 32'h100, "R1");
    // R2 sequential
    for (int i = 0; i < 4; i++) step(1, 0, '0, 30'h0, 0, "R2");
    // R3 branch if zero, taken/not taken, negative imm
    step(1, 1, mk(6'h04, 26'h0010), 30'h100, 0, "R3");
    step(1, 1, mk(6'h04, 26'h0010), 30'h100, 5, "R3");
    step(1, 1, mk(6'h04, 26'hFFFC), 30'h100, 0, "R3");
    step(1, 1, mk(6'h04, 26'h8000), 30'h3000, 0, "R3");
    // R4 branch if nonzero
    step(1, 1, mk(6'h05, 26'h0020), 30'h200, 32'h8000_0000, "R4");
    step(1, 1, mk(6'h05, 26'h0020), 30'h200, 0, "R4");
    step(1, 1, mk(6'h05, 26'hFFFF), 30'h200, 1, "R4");
    // R5 / R6 relative jumps incl. sign boundary
    step(1, 1, mk(6'h02, 26'h0000400), 30'h50, 0, "R5");
    step(1, 1, mk(6'h02, 26'h3FFFFFC), 30'h50, 0, "R5");
    step(1, 1, mk(6'h03, 26'h2000000), 30'h3FFF_FFFF, 7, "R6");
    step(1, 1, mk(6'h03, 26'h0000008), 30'h12, 0, "R6");
    // R7 / R8 register jumps, misaligned values
    step(1, 1, mk(6'h12, 26'h0), 30'h9, 32'h0000_1001, "R7");
    step(1, 1, mk(6'h12, 26'h0), 30'h9, 32'hFFFF_FFFE, "R7");
    step(1, 1, mk(6'h13, 26'h0), 30'hAB, 32'h0000_0803, "R8");
    // R11 invalid slot and foreign opcodes
    step(1, 0, mk(6'h02, 26'h40), 30'h9, 0, "R11");
    step(1, 0, mk(6'h13, 26'h40), 30'h9, 0, "R11");
    step(1, 1, mk(6'h01, 26'h40), 30'h9, 0, "R11");
    step(1, 1, mk(6'h3F, 26'h40), 30'h9, 0, "R11");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] ops [8] = '{6'h04, 6'h05, 6'h02, 6'h03, 6'h12, 6'h13, 6'h00, 6'h2A};
      logic [5:0] op = ops[$urandom_range(0, 7)];
      logic [31:0] rs = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
      step(1, $urandom_range(0, 5) != 0, mk(op, 26'($urandom)), 30'($urandom), rs, "R10");
    end
    // mid-run reset with jump in decode
    step(0, 1, mk(6'h03, 26'h100), 30'h77, 0, "R1");
    step(1, 0, '0, 30'h0, 0, "R2");
    step(1, 0, '0, 30'h0, 0, "R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule